// File: doc/BRIEF.md
# Filtered Wake-Up Request Detector

This block watches two slow signals of a low-power bus interface: a local wake input and a digital bus-dominant indication from a low-power receiver. It turns qualified activity on either signal into a sticky wake-up flag. A separate source flag records whether that flag was set by the local input. Both signals first pass through a two-stage synchroniser. Each then passes a filter that measures, in clock cycles, how long the signal has held a level that counts as a request.

The local input is edge-neutral. A change in either direction counts once the new level has stayed put for the local filter time. The filter then adopts that level as its new reference, so the next request needs a move away from it. The bus signal counts once it has been dominant for the remote filter time. It is counted once per dominant period. The surrounding mode controller supplies the current operating mode, a power-on flag, an undervoltage flag and an undervoltage waiting indication. These decide when the flags may set and when they clear. A one-cycle pulse tells the controller about each new setting of the wake-up flag.

Top module: `wake_req_detect`

## Requirements
- R1: Starting from a clear flag in a low-power mode, a change of `wake_pin` to either level that is held makes `wake_flag` rise exactly at the (LOCAL_CYC+2)-th rising clock edge after the change is applied. It is still low after the (LOCAL_CYC+1)-th edge.
- R2: A `wake_pin` excursion lasting N clock cycles produces a request only when N >= LOCAL_CYC. A shorter excursion restarts the filter and leaves `wake_flag` low.
- R3: Once a local request has been recognised, or the filter time has elapsed in any mode, the settled level becomes the reference. Holding that level produces no further request, and a change away from it produces a new one.
- R4: Holding `bus_dom` high for N cycles produces a request only when N >= REMOTE_CYC. The flag rises exactly at the (REMOTE_CYC+2)-th edge after `bus_dom` goes high.
- R5: `mode` encodings are 0 normal, 1 listen-only, 2 standby, 3 go-to-sleep command and 4 sleep. `wake_flag` can only set in encodings 2, 3 and 4.
- R6: While `uv_wait` is high, no request sets `wake_flag`.
- R7: `wake_flag` is cleared by reset, in normal mode (`mode` = 0), and at the edge where `uv_flag` or `pwon_flag` is first seen high after being low.
- R8: `wake_src_local` sets only when a local request sets `wake_flag` from clear while `pwon_flag` is low. Remote requests never set it.
- R9: `wake_src_local` holds while the mode stays normal. It clears at the edge where the mode changes from normal to another mode, at a rising `pwon_flag`, and on reset.
- R10: `wake_pulse` is high for exactly one cycle each time `wake_flag` goes from clear to set. Requests that arrive while the flag is already set give no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wake_pin | input | 1 | Asynchronous local wake input |
| bus_dom | input | 1 | Asynchronous bus-dominant indication, 1 = dominant |
| mode | input | 3 | Current operating mode (encoding in R5) |
| pwon_flag | input | 1 | Power-on flag from the mode controller |
| uv_flag | input | 1 | Supply undervoltage flag |
| uv_wait | input | 1 | Undervoltage waiting period running |
| wake_flag | output | 1 | Sticky wake-up flag |
| wake_src_local | output | 1 | Wake-up flag was set by the local input |
| wake_pulse | output | 1 | One-cycle pulse on each new wake-up flag setting |

## Verification
Local excursions of every length from one cycle to one past the filter time are applied, in both polarities. These separate a filter that restarts on a glitch from one that accumulates, and they pin the exact latency edge. Bus-dominant bursts just below, at and above the remote time check the second filter the same way. A level change made in normal mode and then held tells a tracking reference apart from a fixed one. Each mode encoding, the undervoltage waiting gate, and the rising power-on and undervoltage flags are applied with a request pending. This shows which condition blocks, which clears, and how the source flag follows.

// File: rtl/wkdet_pkg.sv
package wkdet_pkg;

    typedef enum logic [2:0] {
        MD_NORMAL  = 3'd0,
        MD_LISTEN  = 3'd1,
        MD_STANDBY = 3'd2,
        MD_GOSLEEP = 3'd3,
        MD_SLEEP   = 3'd4
    } op_mode_e;

    typedef struct packed {
        logic local_hit;
        logic remote_hit;
    } wk_req_t;

    function automatic logic mode_can_wake(op_mode_e m);
        return (m == MD_STANDBY) || (m == MD_GOSLEEP) || (m == MD_SLEEP);
    endfunction

    function automatic int cnt_width(int len);
        return (len < 1) ? 1 : $clog2(len + 1);
    endfunction

endpackage

// File: rtl/wkdet_sync.sv
module wkdet_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] st [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) st[i] <= '0;
        end else begin
            st[0] <= d;
            for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
        end
    end

    assign q = st[STAGES-1];
endmodule

// File: rtl/wkdet_filter.sv
module wkdet_filter
    import wkdet_pkg::*;
#(
    parameter int LEN      = 4,
    parameter bit TRACK    = 1'b1,
    parameter bit REF_INIT = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    output logic hit
);
    localparam int            CW   = cnt_width(LEN);
    localparam logic [CW-1:0] LAST = CW'(LEN - 1);
    localparam logic [CW-1:0] DONE = CW'(LEN);

    logic [CW-1:0] cnt;
    logic          ref_q;
    logic          differ;

    assign differ = (lvl != ref_q);
    assign hit    = differ && (cnt == LAST);

    // Qualification counter: restarts whenever the level returns to the reference.
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (!differ) begin
            cnt <= '0;
        end else if (hit) begin
            cnt <= TRACK ? '0 : DONE;
        end else if (cnt != DONE) begin
            cnt <= cnt + 1'b1;
        end
    end

    generate
        if (TRACK) begin : g_track
            always_ff @(posedge clk) begin
                if (rst)      ref_q <= REF_INIT;
                else if (hit) ref_q <= lvl;
            end

            a_r3_ref_follows: assert property (@(posedge clk) disable iff (rst)
                hit |=> (ref_q == $past(lvl)));
        end else begin : g_fixed
            assign ref_q = REF_INIT;

            a_r4_fire_once: assert property (@(posedge clk) disable iff (rst)
                hit |=> !hit);
        end
    endgenerate

    a_r2_cnt_range: assert property (@(posedge clk) disable iff (rst)
        cnt <= DONE);
    a_r2_restart: assert property (@(posedge clk) disable iff (rst)
        (lvl == ref_q) |=> (cnt == '0));
endmodule

// File: rtl/wake_req_detect.sv
module wake_req_detect
    import wkdet_pkg::*;
#(
    parameter int LOCAL_CYC  = 16,
    parameter int REMOTE_CYC = 32
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wake_pin,
    input  logic       bus_dom,
    input  logic [2:0] mode,
    input  logic       pwon_flag,
    input  logic       uv_flag,
    input  logic       uv_wait,
    output logic       wake_flag,
    output logic       wake_src_local,
    output logic       wake_pulse
);
    logic [1:0] sync_q;
    logic       loc_hit, rem_hit;
    wk_req_t    req;
    op_mode_e   md, md_q;
    logic       pwon_q, uv_q;
    logic       pwon_rise, uv_rise, can_set, clr_wake, set_wake, new_set;
    logic       clr_src, set_src;

    wkdet_sync #(.W(2), .STAGES(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({bus_dom, wake_pin}),
        .q   (sync_q)
    );

    wkdet_filter #(.LEN(LOCAL_CYC), .TRACK(1'b1), .REF_INIT(1'b0)) u_local (
        .clk (clk),
        .rst (rst),
        .lvl (sync_q[0]),
        .hit (loc_hit)
    );

    wkdet_filter #(.LEN(REMOTE_CYC), .TRACK(1'b0), .REF_INIT(1'b0)) u_remote (
        .clk (clk),
        .rst (rst),
        .lvl (sync_q[1]),
        .hit (rem_hit)
    );

    always_comb begin
        req.local_hit  = loc_hit;
        req.remote_hit = rem_hit;
    end

    assign md = op_mode_e'(mode);

    // Previous-cycle copies for event detection; loaded every cycle.
    always_ff @(posedge clk) begin
        md_q   <= md;
        pwon_q <= pwon_flag;
        uv_q   <= uv_flag;
    end

    always_comb begin
        pwon_rise = pwon_flag && !pwon_q;
        uv_rise   = uv_flag && !uv_q;
        can_set   = mode_can_wake(md) && !uv_wait;
        clr_wake  = (md == MD_NORMAL) || pwon_rise || uv_rise;
        set_wake  = (req.local_hit || req.remote_hit) && can_set && !clr_wake;
        new_set   = set_wake && !wake_flag;
        clr_src   = ((md_q == MD_NORMAL) && (md != MD_NORMAL)) || pwon_rise;
        set_src   = new_set && req.local_hit && !pwon_flag;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wake_flag      <= 1'b0;
            wake_src_local <= 1'b0;
            wake_pulse     <= 1'b0;
        end else begin
            wake_pulse <= new_set;
            if (clr_wake)      wake_flag <= 1'b0;
            else if (set_wake) wake_flag <= 1'b1;
            if (clr_src)       wake_src_local <= 1'b0;
            else if (set_src)  wake_src_local <= 1'b1;
        end
    end

    a_r5_no_set_active: assert property (@(posedge clk) disable iff (rst)
        (!mode_can_wake(op_mode_e'(mode)) && !wake_flag) |=> !wake_flag);
    a_r6_uv_wait_block: assert property (@(posedge clk) disable iff (rst)
        (uv_wait && !wake_flag) |=> !wake_flag);
    a_r7_uv_rise_clear: assert property (@(posedge clk) disable iff (rst)
        $rose(uv_flag) |=> !wake_flag);
    a_r7_pwon_rise_clear: assert property (@(posedge clk) disable iff (rst)
        $rose(pwon_flag) |=> !wake_flag);
    a_r8_src_needs_flag: assert property (@(posedge clk) disable iff (rst)
        $rose(wake_src_local) |-> (wake_flag && !$past(pwon_flag)));
    a_r9_src_leave_normal: assert property (@(posedge clk) disable iff (rst)
        (($past(mode) == 3'd0) && (mode != 3'd0)) |=> !wake_src_local);
    a_r10_pulse_single: assert property (@(posedge clk) disable iff (rst)
        wake_pulse |=> !wake_pulse);
    a_r10_pulse_with_flag: assert property (@(posedge clk) disable iff (rst)
        wake_pulse |-> (wake_flag && !$past(wake_flag)));
endmodule

// File: tb/wake_req_detect_test.sv
module wake_req_detect_test;
    localparam int LOC = 5;
    localparam int REM = 7;

    logic clk = 1'b0;
    logic rst, wake_pin, bus_dom, pwon_flag, uv_flag, uv_wait;
    logic [2:0] mode;
    logic wake_flag, wake_src_local, wake_pulse;
    int checks = 0;
    int errors = 0;
    int pulses = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    wake_req_detect #(.LOCAL_CYC(LOC), .REMOTE_CYC(REM)) uut (
        .clk            (clk),
        .rst            (rst),
        .wake_pin       (wake_pin),
        .bus_dom        (bus_dom),
        .mode           (mode),
        .pwon_flag      (pwon_flag),
        .uv_flag        (uv_flag),
        .uv_wait        (uv_wait),
        .wake_flag      (wake_flag),
        .wake_src_local (wake_src_local),
        .wake_pulse     (wake_pulse)
    );

    always @(posedge clk) begin
        #2;
        if (wake_pulse === 1'b1) pulses++;
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic chk_int(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic clear_flags();
        mode = 3'd0;
        tick(2);
        mode = 3'd2;
        tick(1);
    endtask

    task automatic local_timed(logic v, string tag);
        wake_pin = v;
        tick(LOC + 1);
        chk(tag, wake_flag, 1'b0);
        tick(1);
        chk(tag, wake_flag, 1'b1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int p0;
        rst = 1'b1; wake_pin = 1'b0; bus_dom = 1'b0; mode = 3'd2;
        pwon_flag = 1'b0; uv_flag = 1'b0; uv_wait = 1'b0;
        tick(3);
        rst = 1'b0;
        tick(1);
        chk("R7 reset wake_flag", wake_flag, 1'b0);
        chk("R9 reset src", wake_src_local, 1'b0);
        chk("R10 reset pulse", wake_pulse, 1'b0);

        // R1 rising change, exact latency; local source; single pulse
        p0 = pulses;
        local_timed(1'b1, "R1 rise latency");
        chk("R8 local sets src", wake_src_local, 1'b1);
        tick(2);
        chk_int("R10 one pulse", pulses, p0 + 1);

        // R10 request while flag set gives no pulse
        wake_pin = 1'b0;
        tick(LOC + 4);
        chk("R10 flag stays set", wake_flag, 1'b1);
        chk_int("R10 no pulse when set", pulses, p0 + 1);

        // R7 / R9 normal mode
        mode = 3'd0;
        tick(1);
        chk("R7 normal clears", wake_flag, 1'b0);
        chk("R9 src held in normal", wake_src_local, 1'b1);
        tick(2);
        chk("R9 src still held", wake_src_local, 1'b1);
        mode = 3'd2;
        tick(1);
        chk("R9 src clears leaving normal", wake_src_local, 1'b0);

        // R1 falling change
        wake_pin = 1'b1;
        tick(LOC + 4);
        clear_flags();
        local_timed(1'b0, "R1 fall latency");
        clear_flags();

        // R3 reference tracking
        tick(3 * LOC);
        chk("R3 settled level no request", wake_flag, 1'b0);
        mode = 3'd0;
        wake_pin = 1'b1;
        tick(LOC + 4);
        chk("R5 normal no set", wake_flag, 1'b0);
        mode = 3'd2;
        tick(3 * LOC);
        chk("R3 ref tracked in normal", wake_flag, 1'b0);
        wake_pin = 1'b0;
        tick(LOC + 4);
        chk("R3 change away sets", wake_flag, 1'b1);

        // R2 glitch sweep
        for (int n = 1; n <= LOC + 1; n++) begin
            clear_flags();
            wake_pin = 1'b1;
            tick(n);
            wake_pin = 1'b0;
            tick(3 * LOC + 4);
            chk("R2 local excursion length", wake_flag, (n >= LOC));
        end

        // R4 remote exact latency and sweep
        clear_flags();
        bus_dom = 1'b1;
        tick(REM + 1);
        chk("R4 remote latency low", wake_flag, 1'b0);
        tick(1);
        chk("R4 remote latency high", wake_flag, 1'b1);
        chk("R8 remote no src", wake_src_local, 1'b0);
        bus_dom = 1'b0;
        tick(3);
        for (int n = REM - 2; n <= REM + 2; n++) begin
            clear_flags();
            bus_dom = 1'b1;
            tick(n);
            bus_dom = 1'b0;
            tick(4);
            chk("R4 dominant length", wake_flag, (n >= REM));
        end

        // R5 mode gating
        clear_flags();
        mode = 3'd1;
        bus_dom = 1'b1;
        tick(REM + 4);
        chk("R5 listen no set", wake_flag, 1'b0);
        bus_dom = 1'b0;
        tick(2);
        mode = 3'd3;
        bus_dom = 1'b1;
        tick(REM + 3);
        chk("R5 gosleep sets", wake_flag, 1'b1);
        bus_dom = 1'b0;
        clear_flags();
        mode = 3'd4;
        p0 = pulses;
        wake_pin = 1'b1;
        tick(LOC + 3);
        chk("R5 sleep sets", wake_flag, 1'b1);
        chk("R8 sleep local src", wake_src_local, 1'b1);
        tick(1);
        chk_int("R10 pulse in sleep", pulses, p0 + 1);

        // R6 undervoltage waiting blocks
        clear_flags();
        uv_wait = 1'b1;
        bus_dom = 1'b1;
        tick(REM + 4);
        chk("R6 uv_wait blocks", wake_flag, 1'b0);
        bus_dom = 1'b0;
        tick(2);
        uv_wait = 1'b0;
        tick(2);
        chk("R6 nothing latent", wake_flag, 1'b0);

        // R7 undervoltage and power-on rising clear
        bus_dom = 1'b1;
        tick(REM + 3);
        chk("R7 set before uv", wake_flag, 1'b1);
        uv_flag = 1'b1;
        tick(1);
        chk("R7 uv rise clears", wake_flag, 1'b0);
        bus_dom = 1'b0;
        uv_flag = 1'b0;
        tick(2);
        bus_dom = 1'b1;
        tick(REM + 3);
        chk("R7 set before pwon", wake_flag, 1'b1);
        pwon_flag = 1'b1;
        tick(1);
        chk("R7 pwon rise clears", wake_flag, 1'b0);
        bus_dom = 1'b0;
        tick(2);

        // R8 power-on flag high blocks source
        wake_pin = 1'b0;
        tick(LOC + 3);
        chk("R8 local with pwon sets flag", wake_flag, 1'b1);
        chk("R8 pwon blocks src", wake_src_local, 1'b0);
        pwon_flag = 1'b0;

        // R9 power-on rise clears source
        clear_flags();
        wake_pin = 1'b1;
        tick(LOC + 3);
        chk("R9 src set", wake_src_local, 1'b1);
        mode = 3'd0;
        tick(1);
        chk("R9 src kept in normal", wake_src_local, 1'b1);
        pwon_flag = 1'b1;
        tick(1);
        chk("R9 pwon clears src", wake_src_local, 1'b0);
        pwon_flag = 1'b0;
        mode = 3'd2;
        tick(2);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule